// File: doc/BRIEF.md
# Multi-Target Load/Store Unit

This unit carries out the memory-access operation of a 16-bit register machine with 32 registers. Each operation is two instruction words presented together with a one-cycle `start` strobe. One transfer is made per operation. It is either a load into a register or a store from a register. The target of the transfer is a software stack kept in main memory, main memory itself, disk storage, video memory, or a byte-wide serial transmitter.

The unit reads its operands through two combinational register-file read ports. It writes results back through one register-file write port. It reaches the storage targets through three word-addressed memory ports, each with a read latency of one cycle. Register 30 serves as the stack pointer and register 31 as the program counter.

A finished operation raises `done` for one cycle, after the program counter has been advanced. An illegal operation raises `halt` for one cycle and changes no state.

Top module: `mt_lsu`

## Requirements
- R1: Bit 7 of `instr_hi` gives the direction (1 = store from the data register, 0 = load into it). Bits 6:4 of `instr_hi` give the target: 0 stack, 1 main memory, 2 disk, 3 video memory, 4 serial. In `instr_lo`, bits 15:11 name the data register and bits 10:6 name the address register.
- R2: A store to main memory, disk or video memory raises the enable of that port only, with write asserted, for one cycle. The address is the address register's value and the write data is the data register's value. At most one target (port enable or `tx_valid`) is active in any cycle.
- R3: A load from main memory, disk or video memory puts the address register's value on that port. It takes the port's read data in the following cycle and writes it into the data register.
- R4: A stack store writes the data register to main memory at the address held in register 30, then writes register 30 minus 1 back to register 30.
- R5: A stack load writes register 30 plus 1 to register 30 and loads main memory at that new address into the data register. When the data register is 30, the loaded word is its final value.
- R6: A serial store drives the low 8 bits of the data register on `tx_data` and holds `tx_valid` and `tx_data` steady until `tx_ready` is seen. The operation then completes.
- R7: A load whose data register is 31 makes no access and writes no register other than register 31, which advances by 2. This rule takes precedence over R8.
- R8: Target codes 5 to 7, and a load from the serial target, raise `halt` for one cycle. In that case there is no access, no register write, no `done`, and the program counter keeps its value.
- R9: Every completed operation adds 2 to register 31, modulo 2^16, and then raises `done` for one cycle.
- R10: `start` is ignored while `busy` is high.
- R11: Under reset, `busy`, `done`, `halt`, `tx_valid`, `rf_we` and all port enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| instr_hi | input | 16 | First instruction word |
| instr_lo | input | 16 | Second instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed (one cycle) |
| halt | output | 1 | Illegal operation (one cycle) |
| rf_ra_idx | output | 5 | Register read port A index |
| rf_ra_data | input | DW | Register read port A data |
| rf_rb_idx | output | 5 | Register read port B index |
| rf_rb_data | input | DW | Register read port B data |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 5 | Register write index |
| rf_wdata | output | DW | Register write data |
| main_en | output | 1 | Main memory access enable |
| main_we | output | 1 | Main memory write |
| main_addr | output | AW | Main memory address |
| main_wdata | output | DW | Main memory write data |
| main_rdata | input | DW | Main memory read data (one-cycle latency) |
| disk_en | output | 1 | Disk access enable |
| disk_we | output | 1 | Disk write |
| disk_addr | output | AW | Disk address |
| disk_wdata | output | DW | Disk write data |
| disk_rdata | input | DW | Disk read data (one-cycle latency) |
| vid_en | output | 1 | Video memory access enable |
| vid_we | output | 1 | Video memory write |
| vid_addr | output | AW | Video memory address |
| vid_wdata | output | DW | Video memory write data |
| vid_rdata | input | DW | Video memory read data (one-cycle latency) |
| tx_valid | output | 1 | Serial character valid |
| tx_data | output | 8 | Serial character |
| tx_ready | input | 1 | Serial transmitter accepts the character |

## Verification
During a stack load, the stack-pointer update and the return of the memory read fall in the same cycle. The bench provokes a collision by popping into register 30 itself. It then checks that register 30 ends up holding the loaded word and not the incremented pointer. A second overlap is a new `start` arriving while an operation is in flight. The bench pulses `start` with a conflicting store during a busy window and checks that no memory or register state shows that store.

// File: rtl/mtlsu_pkg.sv
package mtlsu_pkg;
  localparam int RIX_W = 5;
  localparam logic [RIX_W-1:0] SP_REG = 5'd30;
  localparam logic [RIX_W-1:0] PC_REG = 5'd31;

  localparam logic [2:0] TGT_STACK  = 3'd0;
  localparam logic [2:0] TGT_MAIN   = 3'd1;
  localparam logic [2:0] TGT_DISK   = 3'd2;
  localparam logic [2:0] TGT_VIDEO  = 3'd3;
  localparam logic [2:0] TGT_SERIAL = 3'd4;

  typedef struct packed {
    logic             wr;
    logic [2:0]       tgt;
    logic [RIX_W-1:0] dreg;
    logic [RIX_W-1:0] areg;
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_EXEC, ST_TX, ST_CAP, ST_WB, ST_PCRD, ST_PCWR
  } st_e;
endpackage

// File: rtl/mtlsu_decode.sv
module mtlsu_decode
  import mtlsu_pkg::*;
(
  input  logic [15:0] hi,
  input  logic [15:0] lo,
  output op_t         op,
  output logic        illegal,
  output logic        skip
);
  logic unused_bits;
  assign unused_bits = ^{hi[15:8], hi[3:0], lo[5:0]};

  always_comb begin
    op.wr   = hi[7];
    op.tgt  = hi[6:4];
    op.dreg = lo[15:11];
    op.areg = lo[10:6];
    illegal = (op.tgt > TGT_SERIAL) || (op.tgt == TGT_SERIAL && !op.wr);
    skip    = !op.wr && (op.dreg == PC_REG);
  end
endmodule

// File: rtl/mtlsu_port_mux.sv
module mtlsu_port_mux
  import mtlsu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int NP = 3
) (
  input  logic                   req_en,
  input  logic                   req_we,
  input  logic [2:0]             tgt,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic [DW-1:0]          rdata,
  output logic [NP-1:0]          p_en,
  output logic [NP-1:0]          p_we,
  output logic [NP-1:0][AW-1:0]  p_addr,
  output logic [NP-1:0][DW-1:0]  p_wdata,
  input  logic [NP-1:0][DW-1:0]  p_rdata
);
  localparam int SELW = (NP > 1) ? $clog2(NP) : 1;

  logic [2:0]      port_of;
  logic [SELW-1:0] sel;
  logic            unused_sel;

  // Stack traffic shares the main-memory port
  assign port_of    = (tgt == TGT_STACK) ? 3'd0 : (tgt - 3'd1);
  assign sel        = port_of[SELW-1:0];
  assign unused_sel = ^port_of;

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign p_en[i]    = req_en && (sel == SELW'(i));
    assign p_we[i]    = req_en && req_we && (sel == SELW'(i));
    assign p_addr[i]  = req_addr;
    assign p_wdata[i] = req_wdata;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NP; i++) begin
      if (sel == SELW'(i)) rdata = p_rdata[i];
    end
  end
endmodule

// File: rtl/mtlsu_ctrl.sv
module mtlsu_ctrl
  import mtlsu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  op_t              op_in,
  input  logic             illegal_in,
  input  logic             skip_in,
  output logic             busy,
  output logic             done,
  output logic             halt,
  output logic [RIX_W-1:0] ra_idx,
  input  logic [DW-1:0]    ra_data,
  output logic [RIX_W-1:0] rb_idx,
  input  logic [DW-1:0]    rb_data,
  output logic             rf_we,
  output logic [RIX_W-1:0] rf_widx,
  output logic [DW-1:0]    rf_wdata,
  output logic             req_en,
  output logic             req_we,
  output logic [2:0]       req_tgt,
  output logic [AW-1:0]    req_addr,
  output logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    req_rdata,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready
);
  st_e           st;
  op_t           op_q;
  logic          ill_q, skip_q;
  logic [DW-1:0] dval, aval, rval, pcv;
  logic [DW-1:0] sp_next, addr_word;
  logic          is_stack;

  assign is_stack  = (op_q.tgt == TGT_STACK);
  assign sp_next   = op_q.wr ? (aval - DW'(1)) : (aval + DW'(1));
  assign addr_word = (is_stack && !op_q.wr) ? sp_next : aval;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      op_q   <= '0;
      ill_q  <= 1'b0;
      skip_q <= 1'b0;
      dval   <= '0;
      aval   <= '0;
      rval   <= '0;
      pcv    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q   <= op_in;
          ill_q  <= illegal_in;
          skip_q <= skip_in;
          st     <= ST_RD;
        end
        ST_RD: begin
          dval <= ra_data;
          aval <= rb_data;
          st   <= ST_EXEC;
        end
        ST_EXEC: begin
          if (skip_q)                       st <= ST_PCRD;
          else if (ill_q)                   st <= ST_IDLE;
          else if (op_q.tgt == TGT_SERIAL)  st <= ST_TX;
          else                              st <= ST_CAP;
        end
        ST_TX:   if (tx_ready) st <= ST_PCRD;
        ST_CAP: begin
          rval <= req_rdata;
          st   <= op_q.wr ? ST_PCRD : ST_WB;
        end
        ST_WB:   st <= ST_PCRD;
        ST_PCRD: begin
          pcv <= ra_data;
          st  <= ST_PCWR;
        end
        ST_PCWR: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != ST_IDLE);
    done      = (st == ST_PCWR);
    halt      = (st == ST_EXEC) && !skip_q && ill_q;
    ra_idx    = (st == ST_PCRD) ? PC_REG : op_q.dreg;
    rb_idx    = is_stack ? SP_REG : op_q.areg;
    req_en    = (st == ST_EXEC) && !skip_q && !ill_q && (op_q.tgt != TGT_SERIAL);
    req_we    = op_q.wr;
    req_tgt   = op_q.tgt;
    req_addr  = addr_word[AW-1:0];
    req_wdata = dval;
    tx_valid  = (st == ST_TX);
    tx_data   = dval[7:0];
    rf_we     = 1'b0;
    rf_widx   = op_q.dreg;
    rf_wdata  = rval;
    case (st)
      ST_CAP: if (is_stack) begin
        rf_we    = 1'b1;
        rf_widx  = SP_REG;
        rf_wdata = sp_next;
      end
      ST_WB: rf_we = 1'b1;
      ST_PCWR: begin
        rf_we    = 1'b1;
        rf_widx  = PC_REG;
        rf_wdata = pcv + DW'(2);
      end
      default: ;
    endcase
  end

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we && (rf_widx == PC_REG) |-> rf_wdata == $past(ra_data) + DW'(2));

  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    start && busy |=> $stable(op_q));

  // R8
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !busy && !rf_we);
endmodule

// File: rtl/mt_lsu.sv
module mt_lsu
  import mtlsu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [15:0]      instr_hi,
  input  logic [15:0]      instr_lo,
  output logic             busy,
  output logic             done,
  output logic             halt,
  output logic [4:0]       rf_ra_idx,
  input  logic [DW-1:0]    rf_ra_data,
  output logic [4:0]       rf_rb_idx,
  input  logic [DW-1:0]    rf_rb_data,
  output logic             rf_we,
  output logic [4:0]       rf_widx,
  output logic [DW-1:0]    rf_wdata,
  output logic             main_en,
  output logic             main_we,
  output logic [AW-1:0]    main_addr,
  output logic [DW-1:0]    main_wdata,
  input  logic [DW-1:0]    main_rdata,
  output logic             disk_en,
  output logic             disk_we,
  output logic [AW-1:0]    disk_addr,
  output logic [DW-1:0]    disk_wdata,
  input  logic [DW-1:0]    disk_rdata,
  output logic             vid_en,
  output logic             vid_we,
  output logic [AW-1:0]    vid_addr,
  output logic [DW-1:0]    vid_wdata,
  input  logic [DW-1:0]    vid_rdata,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready
);
  localparam int NP = 3;

  op_t                  dec_op;
  logic                 dec_ill, dec_skip;
  logic                 req_en, req_we;
  logic [2:0]           req_tgt;
  logic [AW-1:0]        req_addr;
  logic [DW-1:0]        req_wdata, req_rdata;
  logic [NP-1:0]        p_en, p_we;
  logic [NP-1:0][AW-1:0] p_addr;
  logic [NP-1:0][DW-1:0] p_wdata, p_rdata;

  mtlsu_decode u_dec (
    .hi(instr_hi), .lo(instr_lo), .op(dec_op), .illegal(dec_ill), .skip(dec_skip)
  );

  mtlsu_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .op_in(dec_op), .illegal_in(dec_ill), .skip_in(dec_skip),
    .busy(busy), .done(done), .halt(halt),
    .ra_idx(rf_ra_idx), .ra_data(rf_ra_data),
    .rb_idx(rf_rb_idx), .rb_data(rf_rb_data),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .req_en(req_en), .req_we(req_we), .req_tgt(req_tgt),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  mtlsu_port_mux #(.DW(DW), .AW(AW), .NP(NP)) u_mux (
    .req_en(req_en), .req_we(req_we), .tgt(req_tgt),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdata(req_rdata),
    .p_en(p_en), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata)
  );

  assign p_rdata[0] = main_rdata;
  assign p_rdata[1] = disk_rdata;
  assign p_rdata[2] = vid_rdata;

  assign main_en = p_en[0];  assign main_we = p_we[0];
  assign main_addr = p_addr[0];  assign main_wdata = p_wdata[0];
  assign disk_en = p_en[1];  assign disk_we = p_we[1];
  assign disk_addr = p_addr[1];  assign disk_wdata = p_wdata[1];
  assign vid_en = p_en[2];  assign vid_we = p_we[2];
  assign vid_addr = p_addr[2];  assign vid_wdata = p_wdata[2];
endmodule

// File: tb/mt_lsu_tb_top.sv
`timescale 1ns/1ps
module mt_lsu_tb_top;
  localparam int DW = 16;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, tx_ready;
  logic [15:0] instr_hi, instr_lo;
  logic busy, done, halt, rf_we, tx_valid;
  logic [4:0] rf_ra_idx, rf_rb_idx, rf_widx;
  logic [DW-1:0] rf_ra_data, rf_rb_data, rf_wdata;
  logic main_en, main_we, disk_en, disk_we, vid_en, vid_we;
  logic [AW-1:0] main_addr, disk_addr, vid_addr;
  logic [DW-1:0] main_wdata, disk_wdata, vid_wdata;
  logic [DW-1:0] main_rdata, disk_rdata, vid_rdata;
  logic [7:0] tx_data;

  mt_lsu #(.DW(DW), .AW(AW)) dut_i (.*);

  logic [15:0] rf [32];
  logic [15:0] m_main [256], m_disk [256], m_vid [256];
  logic [15:0] e_rf [32];
  logic [15:0] e_main [256], e_disk [256], e_vid [256];
  logic [7:0]  tx_seen [$];
  logic [7:0]  tx_exp [$];
  logic        tb_sync = 1'b0;
  int checks = 0, fails = 0, cyc = 0, tx_delay = 0, tx_wait = 0;

  assign rf_ra_data = rf[rf_ra_idx];
  assign rf_rb_data = rf[rf_rb_idx];

  always @(posedge clk) begin
    if (tb_sync) for (int i = 0; i < 32; i++) rf[i] <= e_rf[i];
    else if (rf_we) rf[rf_widx] <= rf_wdata;
  end

  always @(posedge clk) begin
    if (tb_sync) for (int i = 0; i < 256; i++) m_main[i] <= e_main[i];
    else if (main_en && main_we) m_main[main_addr[7:0]] <= main_wdata;
    main_rdata <= (main_en && !main_we) ? m_main[main_addr[7:0]] : 16'hDEAD;
  end
  always @(posedge clk) begin
    if (tb_sync) for (int i = 0; i < 256; i++) m_disk[i] <= e_disk[i];
    else if (disk_en && disk_we) m_disk[disk_addr[7:0]] <= disk_wdata;
    disk_rdata <= (disk_en && !disk_we) ? m_disk[disk_addr[7:0]] : 16'hDEAD;
  end
  always @(posedge clk) begin
    if (tb_sync) for (int i = 0; i < 256; i++) m_vid[i] <= e_vid[i];
    else if (vid_en && vid_we) m_vid[vid_addr[7:0]] <= vid_wdata;
    vid_rdata <= (vid_en && !vid_we) ? m_vid[vid_addr[7:0]] : 16'hDEAD;
  end

  always @(posedge clk) if (!rst && tx_valid && tx_ready) tx_seen.push_back(tx_data);

  always @(negedge clk) begin
    if (tx_valid) begin
      tx_ready <= (tx_wait >= tx_delay);
      tx_wait  <= tx_wait + 1;
    end else begin
      tx_ready <= 1'b0;
      tx_wait  <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R2: per-clock comparison, at most one target active
  always @(negedge clk) begin
    if (!rst) begin
      int n;
      n = 32'(main_en) + 32'(disk_en) + 32'(vid_en) + 32'(tx_valid);
      chk(n <= 1, "R2", "active targets", n, 1);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk(0, "watchdog", "cycles", cyc, 50000);
      summary();
      $finish;
    end
  end

  function automatic logic [15:0] w1(input bit wr, input logic [2:0] t);
    return {8'h05, wr, t, 4'h0};
  endfunction
  function automatic logic [15:0] w2(input logic [4:0] d, input logic [4:0] a);
    return {d, a, 6'h00};
  endfunction

  // Behavioural reference model, whole operation at a time
  task automatic model_exec(input logic [15:0] hi, input logic [15:0] lo, output bit ex_halt);
    logic [4:0] d, a;
    logic [2:0] t;
    bit wr;
    d = lo[15:11]; a = lo[10:6]; t = hi[6:4]; wr = hi[7];
    ex_halt = 0;
    if (!wr && d == 5'd31) begin
      e_rf[31] = e_rf[31] + 16'd2;
      return;
    end
    if (t > 3'd4 || (t == 3'd4 && !wr)) begin
      ex_halt = 1;
      return;
    end
    if (wr) begin
      case (t)
        3'd0: begin e_main[e_rf[30][7:0]] = e_rf[d]; e_rf[30] = e_rf[30] - 16'd1; end
        3'd1: e_main[e_rf[a][7:0]] = e_rf[d];
        3'd2: e_disk[e_rf[a][7:0]] = e_rf[d];
        3'd3: e_vid[e_rf[a][7:0]]  = e_rf[d];
        default: tx_exp.push_back(e_rf[d][7:0]);
      endcase
    end else begin
      case (t)
        3'd0: begin e_rf[30] = e_rf[30] + 16'd1; e_rf[d] = e_main[e_rf[30][7:0]]; end
        3'd1: e_rf[d] = e_main[e_rf[a][7:0]];
        3'd2: e_rf[d] = e_disk[e_rf[a][7:0]];
        default: e_rf[d] = e_vid[e_rf[a][7:0]];
      endcase
    end
    e_rf[31] = e_rf[31] + 16'd2;
  endtask

  task automatic compare_state(input string req);
    bit bad;
    bad = 0;
    for (int i = 0; i < 32; i++)
      if (!bad && rf[i] !== e_rf[i]) begin chk(0, req, $sformatf("r%0d", i), rf[i], e_rf[i]); bad = 1; end
    if (!bad) chk(1, req, "registers", 0, 0);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (!bad && m_main[i] !== e_main[i]) begin chk(0, req, $sformatf("main[%0d]", i), m_main[i], e_main[i]); bad = 1; end
      if (!bad && m_disk[i] !== e_disk[i]) begin chk(0, req, $sformatf("disk[%0d]", i), m_disk[i], e_disk[i]); bad = 1; end
      if (!bad && m_vid[i]  !== e_vid[i])  begin chk(0, req, $sformatf("vid[%0d]", i),  m_vid[i],  e_vid[i]);  bad = 1; end
    end
    if (!bad) chk(1, req, "memories", 0, 0);
    chk(tx_seen.size() == tx_exp.size(), req, "serial count", tx_seen.size(), tx_exp.size());
    for (int i = 0; i < tx_exp.size() && i < tx_seen.size(); i++)
      if (tx_seen[i] !== tx_exp[i]) chk(0, req, "serial char", tx_seen[i], tx_exp[i]);
  endtask

  task automatic sync_env();
    @(negedge clk); tb_sync = 1'b1;
    @(negedge clk); tb_sync = 1'b0;
  endtask

  task automatic run_op(input logic [15:0] hi, input logic [15:0] lo,
                        input string req, input bit junk);
    bit ex_halt, got_done, got_halt;
    int n;
    model_exec(hi, lo, ex_halt);
    @(negedge clk); instr_hi = hi; instr_lo = lo; start = 1'b1;
    @(negedge clk); start = 1'b0;
    got_done = 0; got_halt = 0; n = 0;
    while (!got_done && !got_halt && n < 80) begin
      if (junk && n == 1) begin
        start = 1'b1; instr_hi = w1(1, 3'd1); instr_lo = w2(5'd1, 5'd2);
      end else start = 1'b0;
      if (done) got_done = 1;
      if (halt) got_halt = 1;
      if (!got_done && !got_halt) begin @(negedge clk); n++; end
    end
    start = 1'b0;
    chk(got_done == !ex_halt, req, "done", 32'(got_done), 32'(!ex_halt));
    chk(got_halt == ex_halt, req, "halt", 32'(got_halt), 32'(ex_halt));
    @(posedge clk); @(negedge clk);
    chk(!busy, req, "idle after op", 32'(busy), 0);
    compare_state(req);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; instr_hi = '0; instr_lo = '0;
    for (int i = 0; i < 32; i++) e_rf[i] = 16'(i * 7 + 3);
    e_rf[15] = 16'h1241;
    e_rf[30] = 16'd200;
    e_rf[31] = 16'h0040;
    for (int i = 0; i < 256; i++) begin
      e_main[i] = 16'hA000 + 16'(i);
      e_disk[i] = 16'hB000 + 16'(i);
      e_vid[i]  = 16'hC000 + 16'(i);
    end
    sync_env();
    repeat (3) @(negedge clk);
    // R11
    chk(!busy && !done && !halt, "R11", "status in reset", {busy, done, halt}, 0);
    chk(!rf_we && !tx_valid && !main_en && !disk_en && !vid_en, "R11", "strobes in reset",
        {rf_we, tx_valid, main_en, disk_en, vid_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R11", "idle after reset", 32'(busy), 0);

    run_op(w1(1, 3'd1), w2(5'd3, 5'd4), "R2", 0);     // main store
    run_op(w1(1, 3'd2), w2(5'd5, 5'd6), "R2", 0);     // disk store
    run_op(w1(1, 3'd3), w2(5'd20, 5'd21), "R1", 0);   // field positions, video store
    run_op(w1(0, 3'd1), w2(5'd9, 5'd4), "R3", 0);     // read back main
    run_op(w1(0, 3'd2), w2(5'd10, 5'd11), "R3", 0);   // disk load
    run_op(w1(0, 3'd3), w2(5'd12, 5'd21), "R3", 0);   // video load
    run_op(w1(1, 3'd0), w2(5'd1, 5'd0), "R4", 0);     // push r1
    run_op(w1(1, 3'd0), w2(5'd30, 5'd0), "R4", 0);    // push stack pointer itself
    run_op(w1(0, 3'd0), w2(5'd13, 5'd0), "R5", 0);    // pop into r13
    run_op(w1(0, 3'd0), w2(5'd30, 5'd0), "R5", 0);    // pop into r30: loaded word wins
    tx_delay = 0;
    run_op(w1(1, 3'd4), w2(5'd14, 5'd0), "R6", 0);
    tx_delay = 4;
    run_op(w1(1, 3'd4), w2(5'd15, 5'd0), "R6", 0);    // low byte 8'h41
    run_op(w1(0, 3'd1), w2(5'd31, 5'd4), "R7", 0);    // load to PC skipped
    run_op(w1(0, 3'd6), w2(5'd31, 5'd4), "R7", 0);    // skip beats illegal
    run_op(w1(1, 3'd5), w2(5'd2, 5'd3), "R8", 0);
    run_op(w1(0, 3'd7), w2(5'd2, 5'd3), "R8", 0);
    run_op(w1(0, 3'd4), w2(5'd3, 5'd0), "R8", 0);     // serial load illegal
    run_op(w1(1, 3'd2), w2(5'd7, 5'd8), "R10", 1);    // stray start while busy
    e_rf[31] = 16'hFFFE;
    sync_env();
    run_op(w1(1, 3'd1), w2(5'd16, 5'd17), "R9", 0);   // PC wraps to 0000
    chk(rf[31] == 16'h0000, "R9", "pc wrap", rf[31], 16'h0000);

    summary();
    $finish;
  end
endmodule